// File: doc/BRIEF.md
# Bidirectional GPIO Port with Shared Data Bus

This block is an 8-bit general-purpose I/O port. Each pin can be an input or an output, set one pin at a time. Software uses a small register bus to reach two registers. The first is an output latch. The second is a write-only direction mask. At the pins the block presents separate out, output-enable and in signals. A pad ring or testbench resolves them into a tri-state line.

The same pins double as the low data byte of an external memory bus. While the memory interface asserts its access strobe, the port stops acting as GPIO.
- In a write cycle it drives the memory write data on all eight pins.
- In a read cycle it releases the pins and passes the sampled levels back as read data.
- Every external access also wipes the direction mask. Once the access ends, all pins are inputs until software sets the mask again.

Pin levels pass through a two-stage synchronizer. Both the software read path and the memory read path use the synchronized value.

Top module: `gpio_bus_port`

## Requirements
- R1: After reset, pin_oe is 0x00, pin_out is 0x00 and a read of offset 0x00 returns the synchronized pin levels (all pins are inputs).
- R2: With no external access, bit i of pin_oe equals bit i of the direction mask, and a 1 makes pin i an output.
- R3: A register write at offset 0x00 loads the output latch in every case, whatever the direction bits are. With no external access, pin_out equals the latch.
- R4: A read at offset 0x00 returns, per bit, the latch bit when the direction bit is 1 and the synchronized pin level when it is 0.
- R5: A write at offset 0x02 loads the direction mask. A read at offset 0x02 always returns 0x00.
- R6: Any cycle with ext_active high clears the direction mask, so pin_oe is 0x00 after the access ends until the mask is written again.
- R7: During an external write (ext_active=1, ext_write=1), pin_oe is 0xFF and pin_out equals ext_wdata.
- R8: During an external read (ext_active=1, ext_write=0), pin_oe is 0x00 and ext_rdata carries the synchronized pin levels.
- R9: When an external access and a write to offset 0x02 fall in the same cycle, the mask ends up 0x00.
- R10: A change on pin_in shows up in reads two rising clock edges later, and not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 2 | Register offset: 0x00 latch, 0x02 direction mask |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| ext_active | input | 1 | External memory access in progress |
| ext_write | input | 1 | 1 = external write cycle, 0 = external read cycle |
| ext_wdata | input | 8 | External write data to drive on the pins |
| ext_rdata | output | 8 | Synchronized pin levels for external reads |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Pin drive values |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
Random sequences mix several operations:
- latch writes,
- direction writes,
- external reads and writes,
- pin changes.

Each is checked against a bench model of latch and mask. This separates the per-bit selector from a whole-byte selector. Directed cases cover four situations:
- the reset state;
- a latch written while all pins are inputs and then revealed by setting the mask, which separates "always latch" from "latch only outputs";
- an external access in the same cycle as a mask write, which shows the priority;
- a single-edge versus a two-edge sample of a pin change, which pins the synchronizer depth.

// File: rtl/gpio_bus_pkg.sv
package gpio_bus_pkg;
  localparam int PORT_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 2;
  localparam int SYNC_LEN = 2;

  // per-bit selector: driven bits read the latch, released bits read the pins
  function automatic logic [PORT_W-1:0] pick_read(
    input logic [PORT_W-1:0] dir,
    input logic [PORT_W-1:0] latch,
    input logic [PORT_W-1:0] pins
  );
    logic [PORT_W-1:0] r;
    for (int i = 0; i < PORT_W; i++) r[i] = dir[i] ? latch[i] : pins[i];
    return r;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         data_wr,
  input  logic         ctrl_wr,
  input  logic         ext_active,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] latch_q,
  output logic [W-1:0] dir_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (data_wr) latch_q <= wdata;
  end

  // external access has priority over a software mask write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dir_q <= '0;
    else if (ext_active) dir_q <= '0;
    else if (ctrl_wr) dir_q <= wdata;
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W = 8
) (
  input  logic         ext_active,
  input  logic         ext_write,
  input  logic [W-1:0] ext_wdata,
  input  logic [W-1:0] latch_q,
  input  logic [W-1:0] dir_q,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe
);
  always_comb begin
    if (ext_active) begin
      pin_out = ext_write ? ext_wdata : latch_q;
      pin_oe  = {W{ext_write}};
    end else begin
      pin_out = latch_q;
      pin_oe  = dir_q;
    end
  end
endmodule

// File: rtl/gpio_bus_port.sv
module gpio_bus_port
  import gpio_bus_pkg::*;
#(
  parameter int W     = PORT_W,
  parameter int AW    = ADDR_W,
  parameter int SYNCN = SYNC_LEN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_wr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic          ext_active,
  input  logic          ext_write,
  input  logic [W-1:0]  ext_wdata,
  output logic [W-1:0]  ext_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe
);
  localparam logic [AW-1:0] A_DATA = AW'(OFS_DATA);
  localparam logic [AW-1:0] A_CTRL = AW'(OFS_CTRL);

  // named internal events for the checker
  logic          data_wr;
  logic          ctrl_wr;
  logic [W-1:0]  latch_q;
  logic [W-1:0]  dir_q;
  logic [W-1:0]  pins_sync;

  assign data_wr = reg_wr && (reg_addr == A_DATA);
  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL);

  gpio_sync #(.W(W), .STAGES(SYNCN)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pins_sync)
  );

  gpio_port_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .ext_active(ext_active), .wdata(reg_wdata),
    .latch_q(latch_q), .dir_q(dir_q)
  );

  gpio_pin_mux #(.W(W)) u_mux (
    .ext_active(ext_active), .ext_write(ext_write), .ext_wdata(ext_wdata),
    .latch_q(latch_q), .dir_q(dir_q), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always_comb begin
    if (reg_addr == A_DATA) reg_rdata = pick_read(dir_q, latch_q, pins_sync);
    else reg_rdata = '0;
  end

  assign ext_rdata = pins_sync;
endmodule

// File: rtl/gpio_bus_port_chk.sv
module gpio_bus_port_chk #(
  parameter int W  = 8,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  reg_rdata,
  input logic          ext_active,
  input logic          ext_write,
  input logic [W-1:0]  ext_wdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          data_wr,
  input logic          ctrl_wr,
  input logic [W-1:0]  latch_q,
  input logic [W-1:0]  dir_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0));
  // R2
  gpio_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_active |-> (pin_oe == dir_q));
  // R3
  latch_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_wr |=> (latch_q == $past(reg_wdata)));
  // R5
  ctrl_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == AW'(2)) |-> (reg_rdata == '0));
  // R6
  dir_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_active |=> (dir_q == '0));
  // R7
  ext_wr_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && ext_write) |-> (pin_oe == '1 && pin_out == ext_wdata));
  // R8
  ext_rd_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && !ext_write) |-> (pin_oe == '0));
  // R9
  ext_beats_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_active && ctrl_wr) |=> (pin_oe == '0));
endmodule

bind gpio_bus_port gpio_bus_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ext_active(ext_active), .ext_write(ext_write),
  .ext_wdata(ext_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .data_wr(data_wr), .ctrl_wr(ctrl_wr), .latch_q(latch_q), .dir_q(dir_q)
);

// File: tb/tb_gpio_bus_port.sv
`timescale 1ns/1ps
module tb_gpio_bus_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       ext_active = 1'b0;
  logic       ext_write = 1'b0;
  logic [7:0] ext_wdata = '0;
  logic [7:0] ext_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int errors = 0;
  int checks = 0;
  logic [7:0] m_latch = '0;
  logic [7:0] m_dir = '0;

  always #2 clk = ~clk;

  gpio_bus_port dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ext_active(ext_active),
    .ext_write(ext_write), .ext_wdata(ext_wdata), .ext_rdata(ext_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // bench restatement of the read selector: mask-and-merge form
  function automatic logic [7:0] exp_read(logic [7:0] d, logic [7:0] l, logic [7:0] p);
    return (l & d) | (p & ~d);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic reg_write(logic [1:0] a, logic [7:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 2'd0) m_latch = v;
    if (a == 2'd2) m_dir = v;
  endtask

  task automatic reg_read(logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #0.5 v = reg_rdata;
  endtask

  task automatic set_pins(logic [7:0] v);
    @(negedge clk);
    pin_in = v;
    repeat (2) @(negedge clk);
  endtask

  task automatic ext_cycle(logic wr, logic [7:0] wd);
    @(negedge clk);
    ext_active = 1'b1; ext_write = wr; ext_wdata = wd;
    #0.5;
    if (wr) begin
      check("R7 oe", pin_oe, 8'hFF);
      check("R7 out", pin_out, wd);
    end else begin
      check("R8 oe", pin_oe, 8'h00);
      check("R8 rdata", ext_rdata, pin_in);
    end
    @(negedge clk);
    ext_active = 1'b0;
    m_dir = '0;
    #0.5 check("R6 oe after ext", pin_oe, 8'h00);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #0.5;
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_out, 8'h00);
    set_pins(8'h5A);
    reg_read(2'd0, rd);
    check("R1 read", rd, 8'h5A);

    // R3: latch written while all inputs, then revealed
    reg_write(2'd0, 8'hC3);
    reg_read(2'd0, rd);
    check("R3 hidden latch", rd, 8'h5A);
    reg_write(2'd2, 8'hFF);
    check("R2 oe", pin_oe, 8'hFF);
    check("R3 out", pin_out, 8'hC3);
    reg_read(2'd0, rd);
    check("R4 all out", rd, 8'hC3);

    // R4 mixed directions, R5 ctrl read zero
    reg_write(2'd2, 8'h0F);
    reg_read(2'd0, rd);
    check("R4 mixed", rd, exp_read(8'h0F, 8'hC3, 8'h5A));
    reg_read(2'd2, rd);
    check("R5 ctrl read", rd, 8'h00);

    // R10: one edge not enough, two edges are
    @(negedge clk);
    reg_addr = 2'd0;
    pin_in = 8'hA5;
    @(negedge clk); #0.5;
    check("R10 one edge", reg_rdata, exp_read(8'h0F, 8'hC3, 8'h5A));
    @(negedge clk); #0.5;
    check("R10 two edges", reg_rdata, exp_read(8'h0F, 8'hC3, 8'hA5));

    // R6/R7/R8 external cycles
    ext_cycle(1'b1, 8'h3C);
    reg_write(2'd2, 8'hF0);
    ext_cycle(1'b0, 8'h00);

    // R9 simultaneous ext + ctrl write
    reg_write(2'd2, 8'hAA);
    @(negedge clk);
    reg_addr = 2'd2; reg_wdata = 8'h77; reg_wr = 1'b1; ext_active = 1'b1; ext_write = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ext_active = 1'b0; m_dir = '0;
    #0.5 check("R9 ext wins", pin_oe, 8'h00);

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: reg_write(2'd0, 8'($urandom));
        1: reg_write(2'd2, 8'($urandom));
        2: ext_cycle(1'($urandom), 8'($urandom));
        3: set_pins(8'($urandom));
        default: begin
          reg_read(2'd0, rd);
          check("R4 random read", rd, exp_read(m_dir, m_latch, pin_in));
          check("R2 random oe", pin_oe, m_dir);
          check("R3 random out", pin_out, m_latch);
        end
      endcase
    end
    finish_run();
  end
endmodule